// File: doc/BRIEF.md
# Vertically-Crosswise 4x4 Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product with no clock and no storage. Each operand is split into a high bit pair and a low bit pair. Four small 2x2 multipliers form every pairing of those halves. A short, fixed network of adders then assembles the product from the four partial results, in place of a shift-and-add array.

The two cross products go into a first 4-bit adder. A second 4-bit adder takes that sum together with a word built from the high-by-high and low-by-low results, and its sum gives the middle product bits. A half adder merges the carries of the two adders, and a 2-bit adder folds that pair into the top of the high-by-high result. The block is meant to be dropped into a wider datapath, such as a convolution engine, wherever a narrow unsigned multiply is needed in a single combinational stage.

Top module: `vc_mul4x4`

## Requirements
- R1: Each operand is split into a high pair (bits 3:2) and a low pair (bits 1:0). Four 2x2 multipliers form high-by-high, high-by-low, low-by-high and low-by-low. When both operands have their low pair at zero, the product equals the high-by-high result shifted left by four.
- R2: Product bits 1:0 equal bits 1:0 of the low-by-low result.
- R3: A first 4-bit adder sums the two cross products, a[3:2]*b[1:0] and a[1:0]*b[3:2]. Its 5-bit result (carry and sum) equals their arithmetic sum.
- R4: Product bits 5:2 are the sum output of a second 4-bit adder. That adder adds the first adder's sum to the word whose bits 3:2 are bits 1:0 of high-by-high and whose bits 1:0 are bits 3:2 of low-by-low.
- R5: A half adder combines the carries of the two 4-bit adders. Its 2-bit result, added to bits 3:2 of high-by-high, gives product bits 7:6, and this last addition never carries out of bit 7.
- R6: The block is purely combinational. A change on either operand shows on the product within the same clock period, with no clock edge in between.
- R7: Each 2x2 sub-multiplier is built from AND gates and two half adders and gives a 4-bit result equal to the product of its two 2-bit inputs. When both operands are below 4, the product equals a*b.
- R8: For all 256 operand combinations the product equals a*b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 4 | Unsigned multiplicand |
| b_op | input | 4 | Unsigned multiplier |
| prod | output | 8 | Unsigned product a_op*b_op |

## Verification
The assertions take for granted only that both operands carry settled, known 2-state values whenever they are evaluated. They check the internal adder results against arithmetic on the operand halves, and they check that the final 2-bit addition produces no carry. The stimulus applies every operand pair as a clean step and samples the product one time unit later, so the checks never see a half-updated input. The operands are never driven to X or Z.

// File: rtl/vc_mul_pkg.sv
package vc_mul_pkg;

  localparam int OPND_W = 4;
  localparam int HALF_W = OPND_W / 2;
  localparam int PROD_W = 2 * OPND_W;
  localparam int PART_W = 2 * HALF_W;

  typedef logic [OPND_W-1:0] opnd_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [PART_W-1:0] part_t;
  typedef logic [PROD_W-1:0] prod_t;

  // Reference product of two half-width values, written as plain arithmetic.
  function automatic part_t half_mul_ref(input half_t x, input half_t y);
    return part_t'(x) * part_t'(y);
  endfunction

  // Reference sum of two partial words with carry out.
  function automatic logic [PART_W:0] part_add_ref(input part_t x, input part_t y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Reference full product.
  function automatic prod_t full_mul_ref(input opnd_t x, input opnd_t y);
    return prod_t'(x) * prod_t'(y);
  endfunction

endpackage

// File: rtl/vc_half_add.sv
module vc_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/vc_ripple_add.sv
module vc_ripple_add #(
  parameter int ADD_W = 4
) (
  input  logic [ADD_W-1:0] x,
  input  logic [ADD_W-1:0] y,
  output logic [ADD_W-1:0] sum,
  output logic             cout
);
  logic [ADD_W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < ADD_W; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign cout = carry[ADD_W];
endmodule

// File: rtl/vc_mul2x2.sv
module vc_mul2x2
  import vc_mul_pkg::*;
(
  input  half_t x,
  input  half_t y,
  output part_t p
);
  logic pp0, pp1, pp2, pp3;
  logic c_lo, s_hi, c_hi;

  // R7: AND-gate partial products
  assign pp0 = x[0] & y[0];
  assign pp1 = x[1] & y[0];
  assign pp2 = x[0] & y[1];
  assign pp3 = x[1] & y[1];

  vc_half_add u_ha_lo (.x(pp1), .y(pp2), .s(p[1]), .c(c_lo));
  vc_half_add u_ha_hi (.x(pp3), .y(c_lo), .s(s_hi), .c(c_hi));

  assign p[0] = pp0;
  assign p[2] = s_hi;
  assign p[3] = c_hi;
endmodule

// File: rtl/vc_mul4x4.sv
module vc_mul4x4
  import vc_mul_pkg::*;
(
  input  logic [3:0] a_op,
  input  logic [3:0] b_op,
  output logic [7:0] prod
);
  // R1: operand halves
  half_t a_hi, a_lo, b_hi, b_lo;
  assign a_hi = a_op[OPND_W-1:HALF_W];
  assign a_lo = a_op[HALF_W-1:0];
  assign b_hi = b_op[OPND_W-1:HALF_W];
  assign b_lo = b_op[HALF_W-1:0];

  // Partial products, named for the checker.
  part_t pp_hh, pp_hl, pp_lh, pp_ll;

  vc_mul2x2 u_m_hh (.x(a_hi), .y(b_hi), .p(pp_hh));
  vc_mul2x2 u_m_hl (.x(a_hi), .y(b_lo), .p(pp_hl));
  vc_mul2x2 u_m_lh (.x(a_lo), .y(b_hi), .p(pp_lh));
  vc_mul2x2 u_m_ll (.x(a_lo), .y(b_lo), .p(pp_ll));

  // R3: cross-product adder
  part_t cross_sum;
  logic  cross_cout;
  vc_ripple_add #(.ADD_W(PART_W)) u_add_cross (
    .x(pp_hl), .y(pp_lh), .sum(cross_sum), .cout(cross_cout)
  );

  // R4: middle adder, outer word = {hh low pair, ll high pair}
  part_t outer_word, mid_sum;
  logic  mid_cout;
  assign outer_word = {pp_hh[HALF_W-1:0], pp_ll[PART_W-1:HALF_W]};
  vc_ripple_add #(.ADD_W(PART_W)) u_add_mid (
    .x(cross_sum), .y(outer_word), .sum(mid_sum), .cout(mid_cout)
  );

  // R5: carry merge and top pair
  logic  cy_s, cy_c;
  half_t top_pair;
  logic  top_cout;
  vc_half_add u_ha_cy (.x(cross_cout), .y(mid_cout), .s(cy_s), .c(cy_c));
  vc_ripple_add #(.ADD_W(HALF_W)) u_add_top (
    .x(pp_hh[PART_W-1:HALF_W]), .y({cy_c, cy_s}), .sum(top_pair), .cout(top_cout)
  );

  // R2, R4, R5: product assembly
  assign prod = {top_pair, mid_sum, pp_ll[HALF_W-1:0]};
endmodule

// File: rtl/vc_mul4x4_chk.sv
module vc_mul4x4_chk
  import vc_mul_pkg::*;
(
  input logic [3:0] a_op,
  input logic [3:0] b_op,
  input logic [7:0] prod,
  input part_t      pp_hh,
  input part_t      cross_sum,
  input logic       cross_cout,
  input logic       top_cout
);
  always_comb begin
    // R1
    hh_part_chk: assert (pp_hh == half_mul_ref(a_op[3:2], b_op[3:2]))
      else $error("hh partial product mismatch");
    // R2
    low_bits_chk: assert (prod[1:0] == half_mul_ref(a_op[1:0], b_op[1:0]) % 4)
      else $error("low product bits mismatch");
    // R3
    cross_add_chk: assert ({cross_cout, cross_sum} ==
        part_add_ref(half_mul_ref(a_op[3:2], b_op[1:0]), half_mul_ref(a_op[1:0], b_op[3:2])))
      else $error("cross adder mismatch");
    // R5
    no_top_carry_chk: assert (top_cout == 1'b0)
      else $error("top pair addition carried out");
    // R8
    full_prod_chk: assert (prod == full_mul_ref(a_op, b_op))
      else $error("product mismatch");
  end
endmodule

bind vc_mul4x4 vc_mul4x4_chk u_chk (
  .a_op(a_op), .b_op(b_op), .prod(prod), .pp_hh(pp_hh),
  .cross_sum(cross_sum), .cross_cout(cross_cout), .top_cout(top_cout)
);

// File: tb/vc_mul4x4_test.sv
`timescale 1ns/1ps
module vc_mul4x4_test;
  logic       clk = 1'b0;
  logic [3:0] a_op, b_op;
  logic [7:0] prod;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vc_mul4x4 uut (.a_op(a_op), .b_op(b_op), .prod(prod));

  // Vector = {a, b, expected product}
  localparam int NVEC = 12;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'h0, 4'h0, 8'd0},   {4'hF, 4'hF, 8'd225}, {4'hC, 4'hC, 8'd144},
    {4'h3, 4'h3, 8'd9},   {4'h2, 4'h3, 8'd6},   {4'hC, 4'h3, 8'd36},
    {4'h3, 4'hC, 8'd36},  {4'hA, 4'h5, 8'd50},  {4'h7, 4'h9, 8'd63},
    {4'hF, 4'h1, 8'd15},  {4'hD, 4'hB, 8'd143}, {4'h8, 4'h8, 8'd64}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 9:    return "R2";
      1, 10:   return "R5";
      2, 11:   return "R1";
      3, 4:    return "R7";
      5, 6:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] exp_v);
    total++;
    if (prod !== exp_v) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d got=%0d expected=%0d", req, a_op, b_op, prod, exp_v);
    end
  endtask

  initial begin
    a_op = 4'h0;
    b_op = 4'h0;
    @(negedge clk);
    check("R2", 8'd0);  // idle state: zero operands give zero

    // Table of vectors, one per clock
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      a_op = VEC[i][15:12];
      b_op = VEC[i][11:8];
      #1;
      check(tag_of(i), VEC[i][7:0]);
    end

    // R6: change operands twice in one period, no clock edge between
    @(negedge clk);
    a_op = 4'h6; b_op = 4'h7;
    #1 check("R6", 8'd42);
    a_op = 4'hE; b_op = 4'h3;
    #1 check("R6", 8'd42);
    #1 check("R6", 8'd42);

    // R4: middle bits alone, 5*5 = 25 and 9*6 = 54
    a_op = 4'h5; b_op = 4'h5;
    #1 begin
      total++;
      if (prod[5:2] !== 4'(25 >> 2)) begin
        bad++;
        $display("FAIL R4 mid bits got=%0d expected=%0d", prod[5:2], 25 >> 2);
      end
    end
    a_op = 4'h9; b_op = 4'h6;
    #1 check("R4", 8'd54);

    // R8: exhaustive sweep
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(negedge clk);
        a_op = 4'(x);
        b_op = 4'(y);
        #1;
        check("R8", 8'(x * y));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule